// File: doc/BRIEF.md
# Pad Function Mux

This block decides, for every pad of a 38-pad bank, which of three sources drives the pad's output value and output-disable, and where the pad's input value is delivered. The three sources are the user project, a management special function, and the management general-purpose data register. Each pad has its own management-enable bit. When that bit is clear, the user project owns the pad. When it is set, the special function bound to that pad owns it if that function is enabled. Otherwise the general-purpose register owns it.

Special functions are fixed to pad numbers:

- A diagnostic serial port uses pads 1 to 4.
- A UART uses pads 5 and 6.
- Two interrupt inputs use pads 7 and 12.
- Three monitor outputs use pads 13 to 15.
- An SPI master uses pads 32 to 35.

The block is purely combinational. It sits between the pad ring and the core. Analog pad controls are outside its scope.

Top module: `pad_function_mux`

## Requirements
- R1: When `mgmt_en[i]` is 0, `pad_out[i]` = `usr_out[i]`, `pad_oeb[i]` = `usr_oeb[i]` and `usr_in[i]` = `pad_in[i]`. This holds whatever the special-function enables are.
- R2: When `mgmt_en[i]` is 1 and no special function claims pad i, `pad_out[i]` = `gp_out[i]` and `pad_oeb[i]` = `cfg_oeb[i]`. Whenever `mgmt_en[i]` is 1, `usr_in[i]` is 0.
- R3: `gp_in` equals `pad_in` on every pad at all times, whoever owns the pad.
- R4: When `dbg_off` is 0, the diagnostic serial port claims four pads:
  - pad 1 is its data output, driven from `dbg_sdo`;
  - pad 2 is its data input, delivered on `dbg_sdi`;
  - pad 3 is its chip select, delivered on `dbg_csb`;
  - pad 4 is its clock, delivered on `dbg_sck`.
- R5: When `uart_en` is 1, pad 5 is the UART receive input (delivered on `uart_rx`) and pad 6 is the UART transmit output (driven from `uart_tx`).
- R6: The monitor outputs are each claimed by one bit of `mon_en`:
  - `mon_en[0]` puts `trap_state` on pad 13;
  - `mon_en[2]` puts `core_clk` on pad 14;
  - `mon_en[1]` puts `user_clk` on pad 15.
- R7: `irq_en[0]` claims pad 7 and delivers its value on `irq[0]`. `irq_en[1]` claims pad 12 and delivers its value on `irq[1]`. An interrupt output is 0 when its enable is clear.
- R8: When `spim_en` is 1, the SPI master claims four pads:
  - pad 32 is its clock, driven from `spim_sck`;
  - pad 33 is its chip select, driven from `spim_csb`;
  - pad 34 is its data input, delivered on `spim_sdi`;
  - pad 35 is its data output, driven from `spim_sdo`.
- R9: On a pad owned by a special function, `pad_oeb` is 0 for an output function. For an input function, `pad_oeb` is 1 and `pad_out` is 0.
- R10: A special-function input whose pad it does not own reads its idle value: 1 for `dbg_csb` and `uart_rx`, 0 for `dbg_sdi`, `dbg_sck`, `spim_sdi` and both `irq` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mgmt_en | input | 38 | Per-pad management ownership bit |
| cfg_oeb | input | 38 | Output-disable used when the general-purpose register owns a pad |
| gp_out | input | 38 | General-purpose data register output values |
| gp_in | output | 38 | Pad values read back by management |
| usr_out | input | 38 | User project output values |
| usr_oeb | input | 38 | User project output-disables |
| usr_in | output | 38 | Pad values routed to the user project |
| pad_in | input | 38 | Values seen at the pads |
| pad_out | output | 38 | Values driven to the pads |
| pad_oeb | output | 38 | Output-disable driven to the pads (1 = not driving) |
| dbg_off | input | 1 | Disables the diagnostic serial port pads |
| dbg_sdo | input | 1 | Diagnostic serial data output |
| dbg_sdi | output | 1 | Diagnostic serial data input |
| dbg_csb | output | 1 | Diagnostic serial chip select (active low) |
| dbg_sck | output | 1 | Diagnostic serial clock |
| uart_en | input | 1 | UART pad enable |
| uart_tx | input | 1 | UART transmit data |
| uart_rx | output | 1 | UART receive data |
| mon_en | input | 3 | Monitor enables: bit 0 trap, bit 1 user clock, bit 2 core clock |
| trap_state | input | 1 | Core trap indication |
| core_clk | input | 1 | Core clock to monitor |
| user_clk | input | 1 | User clock to monitor |
| irq_en | input | 2 | Pad interrupt enables |
| irq | output | 2 | Pad interrupt requests |
| spim_en | input | 1 | SPI master pad enable |
| spim_sck | input | 1 | SPI master clock |
| spim_csb | input | 1 | SPI master chip select |
| spim_sdo | input | 1 | SPI master data output |
| spim_sdi | output | 1 | SPI master data input |

## Verification
Two sources can contend for the same pad in one cycle.

- **Special-function enable versus a cleared management bit.** A special-function enable can be set while that pad's management bit is clear. Random stimulus sets enables and ownership bits independently, and directed cases set every enable with every management bit cleared. The user project must win on every pad, and every special input must fall to its idle value.
- **Special function versus the general-purpose register.** Both can be ready on a management-owned pad in the same cycle. With the same random general-purpose data present, the bench judges per pad that the claiming function wins and that the register drives only unclaimed pads.

// File: rtl/pad_mux_pkg.sv
// Package: pad numbers bound to management special functions, the monitor
// enable bit positions and the pad owner encoding.
// Assumes a pad bank of at least 36 pads so every bound pad number exists.
package pad_mux_pkg;

    localparam int PAD_COUNT  = 38;
    localparam int MON_W      = 3;
    localparam int IRQ_W      = 2;

    // Diagnostic serial port
    localparam int P_DBG_SDO  = 1;
    localparam int P_DBG_SDI  = 2;
    localparam int P_DBG_CSB  = 3;
    localparam int P_DBG_SCK  = 4;
    // UART
    localparam int P_UART_RX  = 5;
    localparam int P_UART_TX  = 6;
    // Interrupt inputs
    localparam int P_IRQ_A    = 7;
    localparam int P_IRQ_B    = 12;
    // Monitor outputs
    localparam int P_MON_TRAP = 13;
    localparam int P_MON_CORE = 14;
    localparam int P_MON_USER = 15;
    // SPI master
    localparam int P_SPIM_SCK = 32;
    localparam int P_SPIM_CSB = 33;
    localparam int P_SPIM_SDI = 34;
    localparam int P_SPIM_SDO = 35;

    // Monitor enable bit positions
    localparam int MON_TRAP_BIT = 0;
    localparam int MON_USER_BIT = 1;
    localparam int MON_CORE_BIT = 2;

    typedef enum logic [1:0] {
        OWN_USER    = 2'd0,
        OWN_SPECIAL = 2'd1,
        OWN_GPIO    = 2'd2
    } owner_e;

endpackage

// File: rtl/pad_claim_map.sv
// Module: pad_claim_map
// Builds per-pad vectors saying which pads an enabled special function
// claims, and the value and output-disable that function wants on the pad.
// Input-only functions ask for output 0 and output-disable 1.
// Assumes NPAD exceeds every bound pad number in pad_mux_pkg.
module pad_claim_map
    import pad_mux_pkg::*;
#(
    parameter int NPAD = PAD_COUNT
) (
    input  logic             dbg_off,
    input  logic             dbg_sdo,
    input  logic             uart_en,
    input  logic             uart_tx,
    input  logic [MON_W-1:0] mon_en,
    input  logic             trap_state,
    input  logic             core_clk,
    input  logic             user_clk,
    input  logic [IRQ_W-1:0] irq_en,
    input  logic             spim_en,
    input  logic             spim_sck,
    input  logic             spim_csb,
    input  logic             spim_sdo,
    output logic [NPAD-1:0]  claim,
    output logic [NPAD-1:0]  claim_out,
    output logic [NPAD-1:0]  claim_oeb
);

    logic dbg_on;

    // Purpose: active-high form of the diagnostic port enable.
    always_comb dbg_on = ~dbg_off;

    // Purpose: place each enabled special function onto its fixed pads.
    always_comb begin
        claim     = '0;
        claim_out = '0;
        claim_oeb = '1;

        // Diagnostic serial port: one output, three inputs
        claim[P_DBG_SDO]     = dbg_on;
        claim_out[P_DBG_SDO] = dbg_sdo;
        claim_oeb[P_DBG_SDO] = 1'b0;
        claim[P_DBG_SDI]     = dbg_on;
        claim[P_DBG_CSB]     = dbg_on;
        claim[P_DBG_SCK]     = dbg_on;

        // UART: receive input, transmit output
        claim[P_UART_RX]     = uart_en;
        claim[P_UART_TX]     = uart_en;
        claim_out[P_UART_TX] = uart_tx;
        claim_oeb[P_UART_TX] = 1'b0;

        // Interrupt inputs
        claim[P_IRQ_A]       = irq_en[0];
        claim[P_IRQ_B]       = irq_en[1];

        // Monitor outputs
        claim[P_MON_TRAP]     = mon_en[MON_TRAP_BIT];
        claim_out[P_MON_TRAP] = trap_state;
        claim_oeb[P_MON_TRAP] = 1'b0;
        claim[P_MON_CORE]     = mon_en[MON_CORE_BIT];
        claim_out[P_MON_CORE] = core_clk;
        claim_oeb[P_MON_CORE] = 1'b0;
        claim[P_MON_USER]     = mon_en[MON_USER_BIT];
        claim_out[P_MON_USER] = user_clk;
        claim_oeb[P_MON_USER] = 1'b0;

        // SPI master: three outputs, one input
        claim[P_SPIM_SCK]     = spim_en;
        claim_out[P_SPIM_SCK] = spim_sck;
        claim_oeb[P_SPIM_SCK] = 1'b0;
        claim[P_SPIM_CSB]     = spim_en;
        claim_out[P_SPIM_CSB] = spim_csb;
        claim_oeb[P_SPIM_CSB] = 1'b0;
        claim[P_SPIM_SDI]     = spim_en;
        claim[P_SPIM_SDO]     = spim_en;
        claim_out[P_SPIM_SDO] = spim_sdo;
        claim_oeb[P_SPIM_SDO] = 1'b0;
    end

endmodule

// File: rtl/pad_owner_mux.sv
// Module: pad_owner_mux
// One pad's three-level selector. The user project owns the pad when its
// management bit is clear. Otherwise a claiming special function owns it,
// and failing that the general-purpose data register owns it.
// Assumes claim_out and claim_oeb are meaningful only while claim is set.
module pad_owner_mux
    import pad_mux_pkg::*;
(
    input  logic   mgmt_en,
    input  logic   claim,
    input  logic   claim_out,
    input  logic   claim_oeb,
    input  logic   usr_out,
    input  logic   usr_oeb,
    input  logic   gp_out,
    input  logic   gp_oeb,
    input  logic   pad_in,
    output owner_e owner,
    output logic   pad_out,
    output logic   pad_oeb,
    output logic   usr_in
);

    // Purpose: fixed precedence, user first, then special, then register.
    always_comb begin
        if (!mgmt_en)   owner = OWN_USER;
        else if (claim) owner = OWN_SPECIAL;
        else            owner = OWN_GPIO;
    end

    // Purpose: steer the selected source onto the pad drivers.
    always_comb begin
        case (owner)
            OWN_USER: begin
                pad_out = usr_out;
                pad_oeb = usr_oeb;
            end
            OWN_SPECIAL: begin
                pad_out = claim_out;
                pad_oeb = claim_oeb;
            end
            default: begin
                pad_out = gp_out;
                pad_oeb = gp_oeb;
            end
        endcase
    end

    // Purpose: pass the pad value to the user only while the user owns it.
    always_comb usr_in = (owner == OWN_USER) ? pad_in : 1'b0;

endmodule

// File: rtl/sf_input_route.sv
// Module: sf_input_route
// Delivers pad values to special-function inputs whose pads they own.
// An input whose pad is not owned reads its idle level: high for the
// active-low chip select and the UART line, low for the rest.
module sf_input_route
    import pad_mux_pkg::*;
(
    input  logic             own_dbg_sdi,
    input  logic             own_dbg_csb,
    input  logic             own_dbg_sck,
    input  logic             own_uart_rx,
    input  logic             own_irq_a,
    input  logic             own_irq_b,
    input  logic             own_spim_sdi,
    input  logic             pin_dbg_sdi,
    input  logic             pin_dbg_csb,
    input  logic             pin_dbg_sck,
    input  logic             pin_uart_rx,
    input  logic             pin_irq_a,
    input  logic             pin_irq_b,
    input  logic             pin_spim_sdi,
    output logic             dbg_sdi,
    output logic             dbg_csb,
    output logic             dbg_sck,
    output logic             uart_rx,
    output logic [IRQ_W-1:0] irq,
    output logic             spim_sdi
);

    // Purpose: select the pad value or the idle level per input.
    always_comb begin
        dbg_sdi  = own_dbg_sdi  ? pin_dbg_sdi  : 1'b0;
        dbg_csb  = own_dbg_csb  ? pin_dbg_csb  : 1'b1;
        dbg_sck  = own_dbg_sck  ? pin_dbg_sck  : 1'b0;
        uart_rx  = own_uart_rx  ? pin_uart_rx  : 1'b1;
        irq[0]   = own_irq_a    ? pin_irq_a    : 1'b0;
        irq[1]   = own_irq_b    ? pin_irq_b    : 1'b0;
        spim_sdi = own_spim_sdi ? pin_spim_sdi : 1'b0;
    end

endmodule

// File: rtl/pad_function_mux.sv
// Module: pad_function_mux (top)
// Pad ownership and function mux for a bank of NPAD pads. It combines the
// special-function claim map, one owner selector per pad and the routing of
// special-function inputs. It is purely combinational and adds no latency,
// so the clock monitor pads forward their clocks directly.
// Assumes NPAD >= 36.
module pad_function_mux
    import pad_mux_pkg::*;
#(
    parameter int NPAD = PAD_COUNT
) (
    input  logic [NPAD-1:0]  mgmt_en,
    input  logic [NPAD-1:0]  cfg_oeb,
    input  logic [NPAD-1:0]  gp_out,
    output logic [NPAD-1:0]  gp_in,
    input  logic [NPAD-1:0]  usr_out,
    input  logic [NPAD-1:0]  usr_oeb,
    output logic [NPAD-1:0]  usr_in,
    input  logic [NPAD-1:0]  pad_in,
    output logic [NPAD-1:0]  pad_out,
    output logic [NPAD-1:0]  pad_oeb,
    input  logic             dbg_off,
    input  logic             dbg_sdo,
    output logic             dbg_sdi,
    output logic             dbg_csb,
    output logic             dbg_sck,
    input  logic             uart_en,
    input  logic             uart_tx,
    output logic             uart_rx,
    input  logic [MON_W-1:0] mon_en,
    input  logic             trap_state,
    input  logic             core_clk,
    input  logic             user_clk,
    input  logic [IRQ_W-1:0] irq_en,
    output logic [IRQ_W-1:0] irq,
    input  logic             spim_en,
    input  logic             spim_sck,
    input  logic             spim_csb,
    input  logic             spim_sdo,
    output logic             spim_sdi
);

    logic [NPAD-1:0] claim;
    logic [NPAD-1:0] claim_out;
    logic [NPAD-1:0] claim_oeb;
    logic [NPAD-1:0] sf_owned;
    owner_e          owner [NPAD];

    // Purpose: management readback always sees the pad value.
    always_comb gp_in = pad_in;

    pad_claim_map #(.NPAD(NPAD)) u_claim (
        .dbg_off    (dbg_off),
        .dbg_sdo    (dbg_sdo),
        .uart_en    (uart_en),
        .uart_tx    (uart_tx),
        .mon_en     (mon_en),
        .trap_state (trap_state),
        .core_clk   (core_clk),
        .user_clk   (user_clk),
        .irq_en     (irq_en),
        .spim_en    (spim_en),
        .spim_sck   (spim_sck),
        .spim_csb   (spim_csb),
        .spim_sdo   (spim_sdo),
        .claim      (claim),
        .claim_out  (claim_out),
        .claim_oeb  (claim_oeb)
    );

    for (genvar i = 0; i < NPAD; i++) begin : g_pad
        pad_owner_mux u_sel (
            .mgmt_en   (mgmt_en[i]),
            .claim     (claim[i]),
            .claim_out (claim_out[i]),
            .claim_oeb (claim_oeb[i]),
            .usr_out   (usr_out[i]),
            .usr_oeb   (usr_oeb[i]),
            .gp_out    (gp_out[i]),
            .gp_oeb    (cfg_oeb[i]),
            .pad_in    (pad_in[i]),
            .owner     (owner[i]),
            .pad_out   (pad_out[i]),
            .pad_oeb   (pad_oeb[i]),
            .usr_in    (usr_in[i])
        );

        // Purpose: flag pads currently held by a special function.
        always_comb sf_owned[i] = (owner[i] == OWN_SPECIAL);
    end

    sf_input_route u_route (
        .own_dbg_sdi  (sf_owned[P_DBG_SDI]),
        .own_dbg_csb  (sf_owned[P_DBG_CSB]),
        .own_dbg_sck  (sf_owned[P_DBG_SCK]),
        .own_uart_rx  (sf_owned[P_UART_RX]),
        .own_irq_a    (sf_owned[P_IRQ_A]),
        .own_irq_b    (sf_owned[P_IRQ_B]),
        .own_spim_sdi (sf_owned[P_SPIM_SDI]),
        .pin_dbg_sdi  (pad_in[P_DBG_SDI]),
        .pin_dbg_csb  (pad_in[P_DBG_CSB]),
        .pin_dbg_sck  (pad_in[P_DBG_SCK]),
        .pin_uart_rx  (pad_in[P_UART_RX]),
        .pin_irq_a    (pad_in[P_IRQ_A]),
        .pin_irq_b    (pad_in[P_IRQ_B]),
        .pin_spim_sdi (pad_in[P_SPIM_SDI]),
        .dbg_sdi      (dbg_sdi),
        .dbg_csb      (dbg_csb),
        .dbg_sck      (dbg_sck),
        .uart_rx      (uart_rx),
        .irq          (irq),
        .spim_sdi     (spim_sdi)
    );

endmodule

// File: rtl/pad_mux_chk.sv
// Module: pad_mux_chk
// Checker bound to pad_function_mux. It holds immediate assertions on port
// relations. Since the block has no state, every property is checked
// whenever an input changes.
module pad_mux_chk
    import pad_mux_pkg::*;
#(
    parameter int NPAD = PAD_COUNT
) (
    input logic [NPAD-1:0]  mgmt_en,
    input logic [NPAD-1:0]  gp_in,
    input logic [NPAD-1:0]  usr_out,
    input logic [NPAD-1:0]  usr_oeb,
    input logic [NPAD-1:0]  usr_in,
    input logic [NPAD-1:0]  pad_in,
    input logic [NPAD-1:0]  pad_out,
    input logic [NPAD-1:0]  pad_oeb,
    input logic             dbg_off,
    input logic             dbg_sdi,
    input logic             dbg_csb,
    input logic             dbg_sck,
    input logic [MON_W-1:0] mon_en,
    input logic             trap_state,
    input logic             core_clk,
    input logic             user_clk,
    input logic [IRQ_W-1:0] irq_en,
    input logic [IRQ_W-1:0] irq,
    input logic             spim_en,
    input logic             spim_sck
);

    // Purpose: user ownership passes through all three wires (R1); management
    // ownership cuts the user input (R2).
    always_comb begin
        for (int i = 0; i < NPAD; i++) begin
            if (!mgmt_en[i]) begin
                a_r1_user_drives: assert (pad_out[i] == usr_out[i] &&
                                          pad_oeb[i] == usr_oeb[i] &&
                                          usr_in[i]  == pad_in[i]);
            end else begin
                a_r2_user_input_cut: assert (usr_in[i] == 1'b0);
            end
        end
    end

    // Purpose: management readback tracks the pads (R3).
    always_comb a_r3_readback: assert (gp_in == pad_in);

    // Purpose: a disabled interrupt stays low (R7).
    always_comb a_r7_irq_quiet: assert ((irq & ~irq_en) == '0);

    // Purpose: a disabled diagnostic port sees idle levels (R10).
    always_comb begin
        if (dbg_off) begin
            a_r10_dbg_idle: assert (dbg_csb && !dbg_sdi && !dbg_sck);
        end
    end

    // Purpose: the monitor pads carry their signals when claimed (R6).
    always_comb begin
        if (mon_en[MON_TRAP_BIT] && mgmt_en[P_MON_TRAP]) begin
            a_r6_trap_mon: assert (pad_out[P_MON_TRAP] == trap_state && !pad_oeb[P_MON_TRAP]);
        end
        if (mon_en[MON_CORE_BIT] && mgmt_en[P_MON_CORE]) begin
            a_r6_core_mon: assert (pad_out[P_MON_CORE] == core_clk && !pad_oeb[P_MON_CORE]);
        end
        if (mon_en[MON_USER_BIT] && mgmt_en[P_MON_USER]) begin
            a_r6_user_mon: assert (pad_out[P_MON_USER] == user_clk && !pad_oeb[P_MON_USER]);
        end
    end

    // Purpose: the SPI master clock pad drives when claimed (R8, R9).
    always_comb begin
        if (spim_en && mgmt_en[P_SPIM_SCK]) begin
            a_r8_spim_clock: assert (pad_out[P_SPIM_SCK] == spim_sck && !pad_oeb[P_SPIM_SCK]);
        end
    end

endmodule

bind pad_function_mux pad_mux_chk #(.NPAD(NPAD)) u_chk (.*);

// File: tb/pad_function_mux_test.sv
`timescale 1ns/1ps
module pad_function_mux_test;
    localparam int N = 38;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [N-1:0] mgmt_en = '0, cfg_oeb = '0, gp_out = '0, usr_out = '0;
    logic [N-1:0] usr_oeb = '0, pad_in = '0;
    logic [N-1:0] gp_in, usr_in, pad_out, pad_oeb;
    logic dbg_off = 1'b0, dbg_sdo = 1'b0, uart_en = 1'b0, uart_tx = 1'b0;
    logic trap_state = 1'b0, core_clk = 1'b0, user_clk = 1'b0;
    logic spim_en = 1'b0, spim_sck = 1'b0, spim_csb = 1'b0, spim_sdo = 1'b0;
    logic [2:0] mon_en = '0;
    logic [1:0] irq_en = '0;
    logic dbg_sdi, dbg_csb, dbg_sck, uart_rx, spim_sdi;
    logic [1:0] irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    pad_function_mux uut (.*);

    // Expected values derived from the requirements
    logic [N-1:0] e_out, e_oeb, e_uin;
    logic e_sdi, e_csb, e_sck, e_rx, e_ssdi;
    logic [1:0] e_irq;
    logic [N-1:0] e_claim;
    string tag_of [N];

    task automatic model();
        logic c, co, ce;
        for (int i = 0; i < N; i++) begin
            c = 1'b0; co = 1'b0; ce = 1'b1; tag_of[i] = "R2";
            case (i)
                1:  begin c = !dbg_off; co = dbg_sdo; ce = 1'b0; tag_of[i] = "R4"; end
                2, 3, 4: begin c = !dbg_off; tag_of[i] = "R9"; end
                5:  begin c = uart_en; tag_of[i] = "R9"; end
                6:  begin c = uart_en; co = uart_tx; ce = 1'b0; tag_of[i] = "R5"; end
                7:  begin c = irq_en[0]; tag_of[i] = "R9"; end
                12: begin c = irq_en[1]; tag_of[i] = "R9"; end
                13: begin c = mon_en[0]; co = trap_state; ce = 1'b0; tag_of[i] = "R6"; end
                14: begin c = mon_en[2]; co = core_clk; ce = 1'b0; tag_of[i] = "R6"; end
                15: begin c = mon_en[1]; co = user_clk; ce = 1'b0; tag_of[i] = "R6"; end
                32: begin c = spim_en; co = spim_sck; ce = 1'b0; tag_of[i] = "R8"; end
                33: begin c = spim_en; co = spim_csb; ce = 1'b0; tag_of[i] = "R8"; end
                34: begin c = spim_en; tag_of[i] = "R9"; end
                35: begin c = spim_en; co = spim_sdo; ce = 1'b0; tag_of[i] = "R8"; end
                default: ;
            endcase
            if (!c) tag_of[i] = "R2";
            if (!mgmt_en[i]) begin
                tag_of[i] = "R1";
                e_out[i] = usr_out[i]; e_oeb[i] = usr_oeb[i]; e_uin[i] = pad_in[i];
                e_claim[i] = 1'b0;
            end else if (c) begin
                e_out[i] = co; e_oeb[i] = ce; e_uin[i] = 1'b0; e_claim[i] = 1'b1;
            end else begin
                e_out[i] = gp_out[i]; e_oeb[i] = cfg_oeb[i]; e_uin[i] = 1'b0;
                e_claim[i] = 1'b0;
            end
        end
        e_sdi  = e_claim[2]  ? pad_in[2]  : 1'b0;
        e_csb  = e_claim[3]  ? pad_in[3]  : 1'b1;
        e_sck  = e_claim[4]  ? pad_in[4]  : 1'b0;
        e_rx   = e_claim[5]  ? pad_in[5]  : 1'b1;
        e_irq  = {e_claim[12] ? pad_in[12] : 1'b0, e_claim[7] ? pad_in[7] : 1'b0};
        e_ssdi = e_claim[34] ? pad_in[34] : 1'b0;
    endtask

    task automatic chk1(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // Drive at the rising edge, compare at the falling edge
    task automatic check_all(string label);
        @(negedge clk);
        model();
        for (int i = 0; i < N; i++) begin
            checks++;
            if (pad_out[i] !== e_out[i] || pad_oeb[i] !== e_oeb[i] || usr_in[i] !== e_uin[i]) begin
                errors++;
                $display("FAIL %s [%s] pad %0d: actual out=%b oeb=%b uin=%b expected out=%b oeb=%b uin=%b",
                         tag_of[i], label, i, pad_out[i], pad_oeb[i], usr_in[i],
                         e_out[i], e_oeb[i], e_uin[i]);
            end
        end
        checks++;
        if (gp_in !== pad_in) begin
            errors++;
            $display("FAIL R3 [%s] gp_in: actual %h expected %h", label, gp_in, pad_in);
        end
        chk1(e_claim[2] ? "R4" : "R10", "dbg_sdi", dbg_sdi, e_sdi);
        chk1(e_claim[3] ? "R4" : "R10", "dbg_csb", dbg_csb, e_csb);
        chk1(e_claim[4] ? "R4" : "R10", "dbg_sck", dbg_sck, e_sck);
        chk1(e_claim[5] ? "R5" : "R10", "uart_rx", uart_rx, e_rx);
        chk1("R7", "irq0", irq[0], e_irq[0]);
        chk1("R7", "irq1", irq[1], e_irq[1]);
        chk1(e_claim[34] ? "R8" : "R10", "spim_sdi", spim_sdi, e_ssdi);
    endtask

    task automatic randomize_all();
        mgmt_en = {$urandom, $urandom};
        cfg_oeb = {$urandom, $urandom};
        gp_out  = {$urandom, $urandom};
        usr_out = {$urandom, $urandom};
        usr_oeb = {$urandom, $urandom};
        pad_in  = {$urandom, $urandom};
        {dbg_off, dbg_sdo, uart_en, uart_tx, trap_state, core_clk, user_clk} = 7'($urandom);
        {spim_en, spim_sck, spim_csb, spim_sdo} = 4'($urandom);
        mon_en = 3'($urandom);
        irq_en = 2'($urandom);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        // R1: everything idle at start, user owns all pads
        @(posedge clk);
        check_all("R1 start");

        // R1: every special enable set but no management ownership
        @(posedge clk);
        mgmt_en = '0; usr_out = {$urandom, $urandom}; usr_oeb = {$urandom, $urandom};
        pad_in = '1; dbg_off = 1'b0; uart_en = 1'b1; mon_en = 3'b111; irq_en = 2'b11;
        spim_en = 1'b1;
        check_all("R1 user wins, R10 idle inputs");

        // R4..R9: everything managed and enabled
        @(posedge clk);
        mgmt_en = '1; gp_out = '1; cfg_oeb = '0; pad_in = {$urandom, $urandom};
        dbg_sdo = 1'b1; uart_tx = 1'b0; trap_state = 1'b1; core_clk = 1'b0;
        user_clk = 1'b1; spim_sck = 1'b1; spim_csb = 1'b0; spim_sdo = 1'b1;
        check_all("R4 R5 R6 R7 R8 R9 all claimed");

        // R10 and R2: debug port off, register takes pads 1-4
        @(posedge clk);
        dbg_off = 1'b1; pad_in = '1;
        check_all("R10 debug off, R2 register");

        // R7: interrupt enables clear with high pads
        @(posedge clk);
        irq_en = 2'b00;
        check_all("R7 irq disabled");

        // R6: each monitor bit alone
        for (int m = 0; m < 3; m++) begin
            @(posedge clk);
            mon_en = 3'(1 << m); core_clk = 1'b1; user_clk = 1'b0; trap_state = 1'b0;
            check_all("R6 single monitor");
        end

        // Random mix
        for (int k = 0; k < 400; k++) begin
            @(posedge clk);
            randomize_all();
            check_all("random");
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule